// File: doc/BRIEF.md
# Texture Environment Combiner Stage

This block is a single stage of a fixed-function pixel colour combiner. Each accepted pixel carries two control words, one steering the three colour lanes and one steering the alpha lane, plus texture, rasterised and constant RGBA inputs. Each lane picks four operands (a, b, c, d). Operands come from the four internal working registers, the pixel inputs or fixed constants. The lane then produces either a blended arithmetic value or the result of a comparison, and writes it into one of the four working registers.

The working registers are both the stage's output and the source of its register operands. A sequence of pixels through the stage can therefore build on earlier results: load constants, accumulate, or compare. All sixteen register channels are visible on one flat output bus.

Top module: `tev_stage`

## Requirements
- R1: While `rst_n` is low, every register channel is cleared to zero and `in_ready` is low. Once reset is released, `in_ready` is high.
- R2: Colour control word field positions:
  - d at bits 3:0, c at 7:4, b at 11:8, a at 15:12.
  - bias at 17:16, op at 18, clamp at 19, shift at 21:20, destination at 23:22.
  Colour operand codes 0-15 select, in this order:
  - working register 0 (W0) colour, then W0 alpha;
  - W1 colour, then W1 alpha;
  - W2 colour, then W2 alpha;
  - W3 colour, then W3 alpha;
  - texture colour, then texture alpha;
  - raster colour, then raster alpha;
  - 255, 128, the constant input's colour, and 0.
  The "alpha" codes broadcast the alpha channel to all three colour lanes. Operands a, b and c use the low 8 bits of a register; d uses the full signed 11-bit value.
- R3: The alpha control word keeps the same bias, op, clamp, shift and destination positions as the colour word. Its operand fields are d at 6:4, c at 9:7, b at 12:10 and a at 15:13. Alpha operand codes 0-7 select, in this order: W0-W3 alpha, texture alpha, raster alpha, constant alpha, and 0.
- R4: With bias code 0-2, a lane first forms L = floor((a·(255−c) + b·c)/255). The sum is then d+L when op=0, or d−L when op=1.
- R5: The bias code adds 0 (code 0), +128 (code 1) or −128 (code 2) after the R4 sum.
- R6: The shift code then scales the biased sum: ×1 (code 0), ×2 (code 1), ×4 (code 2), or an arithmetic halving that rounds toward minus infinity (code 3).
- R7: With clamp=1, the final lane value saturates to 0..255. With clamp=0, it saturates to −1024..1023.
- R8: Bias code 3 selects compare mode. In this mode the lane result is d+c when the test holds and d otherwise, saturated as in R7, with no bias or scaling. op=0 tests a>b and op=1 tests a==b. For the colour lanes, shift selects the operands compared:
  - 0: red only (8 bits);
  - 1: {green, red} (16 bits);
  - 2: {blue, green, red} (24 bits);
  - 3: each channel against itself.
  In codes 0-2, one test result applies to all three lanes.
- R9: In alpha compare mode, shift=3 compares the alpha a and b operands. Shift 0-2 apply the packed tests of R8 to the colour lanes' a and b operands.
- R10: Register channel layout on `regs_o`: channel ch (0=R, 1=G, 2=B, 3=A) of register r sits at bits [(4r+ch)·11 +: 11]. On an accepted pixel, the colour result is written to R, G and B of the colour destination register, and the alpha result is written to A of the alpha destination register. Destination codes 0-3 name W0-W3, and no other channel changes. Input RGBA buses place R at bits 7:0, G at 15:8, B at 23:16 and A at 31:24.
- R11: A pixel is accepted when `in_valid` and `in_ready` are both high, and its result is visible after that clock edge. Without acceptance, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Stage can accept a pixel |
| color_ctl | input | 24 | Colour lane control word |
| alpha_ctl | input | 20 | Alpha lane control word, bits 23:4 |
| tex_rgba | input | 32 | Texture RGBA sample |
| ras_rgba | input | 32 | Rasterised RGBA colour |
| konst_rgba | input | 32 | Constant RGBA colour |
| regs_o | output | 176 | All four working registers, four signed 11-bit channels each |

## Verification
The assertions take for granted that the control words and pixel buses hold known values whenever `in_valid` is high. They also assume that `in_valid` alone marks a new pixel, since the stage never back-pressures outside reset. The stimulus meets these conditions by driving every input from fully defined random or swept values at the falling edge, and by lowering `in_valid` between pixels. Register contents, including negative and saturated values, arise only from earlier accepted pixels, so every operand the bench feeds back stays in the signed 11-bit range.

// File: rtl/tev_stage.sv
module tev_stage #(
  parameter int CW = 8,
  parameter int RW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [23:0]       color_ctl,
  input  logic [23:4]       alpha_ctl,
  input  logic [4*CW-1:0]   tex_rgba,
  input  logic [4*CW-1:0]   ras_rgba,
  input  logic [4*CW-1:0]   konst_rgba,
  output logic [16*RW-1:0]  regs_o
);
  localparam int NREG = 4;
  localparam int NCH  = 4;
  localparam int IW   = RW + 4;
  localparam int PW   = 2*CW + 1;
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] HALF = {1'b1, {(CW-1){1'b0}}};
  localparam logic signed [IW-1:0] SHI = IW'((1 << (RW-1)) - 1);
  localparam logic signed [IW-1:0] SLO = ~SHI;
  localparam logic signed [IW-1:0] CHI = $signed({{(IW-CW){1'b0}}, MAXV});

  logic signed [RW-1:0] rf [NREG][NCH];
  logic fire;

  assign in_ready = rst_n;
  assign fire = in_valid & in_ready;

  genvar gr, gc;
  generate
    for (gr = 0; gr < NREG; gr++) begin : g_reg
      for (gc = 0; gc < NCH; gc++) begin : g_ch
        assign regs_o[(gr*NCH+gc)*RW +: RW] = rf[gr][gc];
      end
    end
  endgenerate

  function automatic logic signed [RW-1:0] zr(input logic [CW-1:0] v);
    return $signed({{(RW-CW){1'b0}}, v});
  endfunction

  function automatic logic cmp_test(input logic [1:0] sh, input logic op,
                                    input logic [CW-1:0] la, lb,
                                    input logic [3*CW-1:0] pa, pb);
    logic gt, eq;
    case (sh)
      2'd0: begin gt = pa[CW-1:0] > pb[CW-1:0];     eq = pa[CW-1:0] == pb[CW-1:0];     end
      2'd1: begin gt = pa[2*CW-1:0] > pb[2*CW-1:0]; eq = pa[2*CW-1:0] == pb[2*CW-1:0]; end
      2'd2: begin gt = pa > pb;                     eq = pa == pb;                     end
      default: begin gt = la > lb;                  eq = la == lb;                     end
    endcase
    return op ? eq : gt;
  endfunction

  function automatic logic signed [RW-1:0] lane_calc(
      input logic [CW-1:0] a, b, c, input logic signed [RW-1:0] d,
      input logic [1:0] bias, shift, input logic op, clamp, tst);
    logic [PW-1:0] prod;
    logic [PW-1:0] q;
    logic signed [IW-1:0] s, dx, lv, cx;
    prod = PW'(a) * PW'(MAXV - c) + PW'(b) * PW'(c);
    q    = (prod + (prod >> CW) + PW'(1)) >> CW;
    dx   = IW'(d);
    lv   = $signed({{(IW-CW){1'b0}}, q[CW-1:0]});
    cx   = $signed({{(IW-CW){1'b0}}, c});
    if (bias == 2'd3) begin
      s = tst ? dx + cx : dx;
    end else begin
      s = op ? dx - lv : dx + lv;
      if (bias == 2'd1) s = s + $signed({{(IW-CW){1'b0}}, HALF});
      if (bias == 2'd2) s = s - $signed({{(IW-CW){1'b0}}, HALF});
      case (shift)
        2'd1:    s = s <<< 1;
        2'd2:    s = s <<< 2;
        2'd3:    s = s >>> 1;
        default: s = s;
      endcase
    end
    if (clamp) begin
      if (s > CHI) s = CHI;
      else if (s < 0) s = '0;
    end else begin
      if (s > SHI) s = SHI;
      else if (s < SLO) s = SLO;
    end
    return RW'(s);
  endfunction

  logic signed [RW-1:0] csrc [3][16];
  logic signed [RW-1:0] asrc [8];
  logic [CW-1:0]        opa [NCH];
  logic [CW-1:0]        opb [NCH];
  logic [CW-1:0]        opc [NCH];
  logic signed [RW-1:0] opd [NCH];
  logic                 tst [NCH];
  logic signed [RW-1:0] res [NCH];
  logic [3*CW-1:0]      pa, pb;

  always_comb begin
    for (int ch = 0; ch < 3; ch++) begin
      for (int k = 0; k < NREG; k++) begin
        csrc[ch][2*k]   = rf[k][ch];
        csrc[ch][2*k+1] = rf[k][3];
      end
      csrc[ch][8]  = zr(tex_rgba[ch*CW +: CW]);
      csrc[ch][9]  = zr(tex_rgba[3*CW +: CW]);
      csrc[ch][10] = zr(ras_rgba[ch*CW +: CW]);
      csrc[ch][11] = zr(ras_rgba[3*CW +: CW]);
      csrc[ch][12] = zr(MAXV);
      csrc[ch][13] = zr(HALF);
      csrc[ch][14] = zr(konst_rgba[ch*CW +: CW]);
      csrc[ch][15] = '0;
      opa[ch] = csrc[ch][color_ctl[15:12]][CW-1:0];
      opb[ch] = csrc[ch][color_ctl[11:8]][CW-1:0];
      opc[ch] = csrc[ch][color_ctl[7:4]][CW-1:0];
      opd[ch] = csrc[ch][color_ctl[3:0]];
    end
    for (int k = 0; k < NREG; k++) asrc[k] = rf[k][3];
    asrc[4] = zr(tex_rgba[3*CW +: CW]);
    asrc[5] = zr(ras_rgba[3*CW +: CW]);
    asrc[6] = zr(konst_rgba[3*CW +: CW]);
    asrc[7] = '0;
    opa[3] = asrc[alpha_ctl[15:13]][CW-1:0];
    opb[3] = asrc[alpha_ctl[12:10]][CW-1:0];
    opc[3] = asrc[alpha_ctl[9:7]][CW-1:0];
    opd[3] = asrc[alpha_ctl[6:4]];
    pa = {opa[2], opa[1], opa[0]};
    pb = {opb[2], opb[1], opb[0]};
    for (int ch = 0; ch < 3; ch++) begin
      tst[ch] = cmp_test(color_ctl[21:20], color_ctl[18], opa[ch], opb[ch], pa, pb);
      res[ch] = lane_calc(opa[ch], opb[ch], opc[ch], opd[ch], color_ctl[17:16],
                          color_ctl[21:20], color_ctl[18], color_ctl[19], tst[ch]);
    end
    tst[3] = cmp_test(alpha_ctl[21:20], alpha_ctl[18], opa[3], opb[3], pa, pb);
    res[3] = lane_calc(opa[3], opb[3], opc[3], opd[3], alpha_ctl[17:16],
                       alpha_ctl[21:20], alpha_ctl[18], alpha_ctl[19], tst[3]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int ch = 0; ch < NCH; ch++)
          rf[r][ch] <= '0;
    end else if (fire) begin
      for (int ch = 0; ch < 3; ch++) rf[color_ctl[23:22]][ch] <= res[ch];
      rf[alpha_ctl[23:22]][3] <= res[3];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> regs_o == '0); // R1
  AST_COLOR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && color_ctl[19] |=> rf[$past(color_ctl[23:22])][0] >= 0 &&
                              rf[$past(color_ctl[23:22])][0] <= zr(MAXV)); // R7
  AST_ALPHA_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && alpha_ctl[19] |=> rf[$past(alpha_ctl[23:22])][3] >= 0 &&
                              rf[$past(alpha_ctl[23:22])][3] <= zr(MAXV)); // R7
  AST_CMP_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire && color_ctl[17:16] == 2'd3 && !color_ctl[19]
      |=> rf[$past(color_ctl[23:22])][0] >= $past(opd[0])); // R8
  AST_W0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    fire && color_ctl[23:22] != 2'd0 && alpha_ctl[23:22] != 2'd0
      |=> $stable(regs_o[NCH*RW-1:0])); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(regs_o)); // R11
endmodule

// File: tb/test_tev_stage.sv
module test_tev_stage;
  localparam int RW = 11;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [23:0] color_ctl = '0;
  logic [23:4] alpha_ctl = '0;
  logic [31:0] tex_rgba = '0, ras_rgba = '0, konst_rgba = '0;
  logic [16*RW-1:0] regs_o;
  int checks = 0, errors = 0;
  int m [4][4];

  tev_stage i_tev_stage (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .color_ctl(color_ctl), .alpha_ctl(alpha_ctl), .tex_rgba(tex_rgba),
    .ras_rgba(ras_rgba), .konst_rgba(konst_rgba), .regs_o(regs_o));

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int byte_of(logic [31:0] v, int ch);
    return int'(v[ch*8 +: 8]);
  endfunction

  function automatic int src_c(int code, int ch, bit full);
    int v;
    if (code < 8) v = m[code/2][(code % 2) ? 3 : ch];
    else case (code)
      8: v = byte_of(tex_rgba, ch);   9: v = byte_of(tex_rgba, 3);
      10: v = byte_of(ras_rgba, ch);  11: v = byte_of(ras_rgba, 3);
      12: v = 255; 13: v = 128;
      14: v = byte_of(konst_rgba, ch);
      default: v = 0;
    endcase
    return full ? v : (v & 255);
  endfunction

  function automatic int src_a(int code, bit full);
    int v;
    case (code)
      0, 1, 2, 3: v = m[code][3];
      4: v = byte_of(tex_rgba, 3);
      5: v = byte_of(ras_rgba, 3);
      6: v = byte_of(konst_rgba, 3);
      default: v = 0;
    endcase
    return full ? v : (v & 255);
  endfunction

  function automatic bit ref_test(int sh, int op, int la, int lb, int pa, int pb);
    int x, y;
    if (sh == 3) begin x = la; y = lb; end
    else if (sh == 0) begin x = pa & 255; y = pb & 255; end
    else if (sh == 1) begin x = pa & 65535; y = pb & 65535; end
    else begin x = pa; y = pb; end
    return op ? (x == y) : (x > y);
  endfunction

  function automatic int ref_lane(int a, int b, int c, int d, int bias, int sh, int op,
                                  int cl, bit t);
    int v, l;
    if (bias == 3) v = d + (t ? c : 0);
    else begin
      l = (a * (255 - c) + b * c) / 255;
      v = op ? d - l : d + l;
      if (bias == 1) v += 128;
      if (bias == 2) v -= 128;
      if (sh == 1) v = v * 2;
      else if (sh == 2) v = v * 4;
      else if (sh == 3) v = v >>> 1;
    end
    if (cl != 0) begin if (v > 255) v = 255; if (v < 0) v = 0; end
    else begin if (v > 1023) v = 1023; if (v < -1024) v = -1024; end
    return v;
  endfunction

  task automatic model_step(logic [23:0] cc, logic [23:4] ac);
    int a[4], b[4], c[4], d[4], r[4];
    int pa, pb;
    for (int ch = 0; ch < 3; ch++) begin
      a[ch] = src_c(int'(cc[15:12]), ch, 0); b[ch] = src_c(int'(cc[11:8]), ch, 0);
      c[ch] = src_c(int'(cc[7:4]), ch, 0);   d[ch] = src_c(int'(cc[3:0]), ch, 1);
    end
    a[3] = src_a(int'(ac[15:13]), 0); b[3] = src_a(int'(ac[12:10]), 0);
    c[3] = src_a(int'(ac[9:7]), 0);   d[3] = src_a(int'(ac[6:4]), 1);
    pa = a[0] | (a[1] << 8) | (a[2] << 16);
    pb = b[0] | (b[1] << 8) | (b[2] << 16);
    for (int ch = 0; ch < 3; ch++)
      r[ch] = ref_lane(a[ch], b[ch], c[ch], d[ch], int'(cc[17:16]), int'(cc[21:20]),
                       int'(cc[18]), int'(cc[19]),
                       ref_test(int'(cc[21:20]), int'(cc[18]), a[ch], b[ch], pa, pb));
    r[3] = ref_lane(a[3], b[3], c[3], d[3], int'(ac[17:16]), int'(ac[21:20]),
                    int'(ac[18]), int'(ac[19]),
                    ref_test(int'(ac[21:20]), int'(ac[18]), a[3], b[3], pa, pb));
    for (int ch = 0; ch < 3; ch++) m[cc[23:22]][ch] = r[ch];
    m[ac[23:22]][3] = r[3];
  endtask

  task automatic check_regs(string tag);
    bit bad = 0;
    int got;
    checks++;
    for (int r = 0; r < 4; r++)
      for (int ch = 0; ch < 4; ch++) begin
        got = int'($signed(regs_o[(r*4+ch)*RW +: RW]));
        if (got !== m[r][ch]) begin
          bad = 1;
          $display("FAIL %s reg %0d ch %0d: actual %0d expected %0d", tag, r, ch, got, m[r][ch]);
        end
      end
    if (bad) errors++;
  endtask

  task automatic xact(logic [23:0] cc, logic [23:4] ac, string tag);
    @(negedge clk);
    color_ctl = cc; alpha_ctl = ac; in_valid = 1'b1;
    model_step(cc, ac);
    @(posedge clk);
    #5;
    in_valid = 1'b0;
    check_regs(tag);
  endtask

  task automatic new_pixel(bit force_eq);
    tex_rgba = $urandom; konst_rgba = $urandom;
    ras_rgba = force_eq ? tex_rgba : $urandom;
  endtask

  task automatic load_const(int r, logic [31:0] k);
    @(negedge clk);
    konst_rgba = k;
    xact({r[1:0], 6'b0, 16'hFFFE}, {r[1:0], 6'b0, 12'hFFE}, "R10");
  endtask

  logic [23:0] cc;
  logic [23:4] ac;

  initial begin
    for (int r = 0; r < 4; r++) for (int ch = 0; ch < 4; ch++) m[r][ch] = 0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (in_ready !== 1'b0) begin errors++; $display("FAIL R1 ready in reset: actual %0b expected 0", in_ready); end
    check_regs("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    checks++;
    if (in_ready !== 1'b1) begin errors++; $display("FAIL R1 ready after reset: actual %0b expected 1", in_ready); end

    load_const(0, 32'h10_20_30_40);
    load_const(1, 32'h80_7F_01_FF);
    load_const(2, 32'h05_AA_55_C3);
    load_const(3, 32'hFE_00_99_66);
    new_pixel(0);
    xact({2'd1, 2'd2, 1'b0, 1'b1, 2'd0, 16'hFCFE}, {2'd1, 2'd2, 1'b0, 1'b1, 2'd0, 12'hFFE}, "R6");

    for (int k = 0; k < 16; k++) begin
      new_pixel(0);
      xact({2'd2, 6'b0, 12'hFFF, k[3:0]}, {2'd2, 6'b0, 9'h1FF, 3'd7}, "R2");
      xact({2'd3, 6'b0, 4'd15, 4'd15, k[3:0], 4'd12}, {2'd0, 6'b0, 12'hFFF}, "R2");
      xact({2'd2, 6'b0, k[3:0], 4'd15, 4'd15, 4'd15}, {2'd3, 6'b0, 12'hFFF}, "R2");
    end
    for (int k = 0; k < 8; k++) begin
      new_pixel(0);
      xact({2'd1, 6'b0, 16'hFFFF}, {2'd0, 6'b0, 3'd7, 3'd7, 3'd7, k[2:0]}, "R3");
      xact({2'd1, 6'b0, 16'hFFFF}, {2'd1, 6'b0, k[2:0], 3'd7, 3'd7, 3'd7}, "R3");
      xact({2'd1, 6'b0, 16'hFFFF}, {2'd2, 6'b0, 3'd7, k[2:0], $urandom_range(7, 0), 3'd6}, "R3");
    end
    for (int op = 0; op < 2; op++)
      for (int rep = 0; rep < 30; rep++) begin
        new_pixel(0);
        cc = $urandom; ac = $urandom;
        cc[18] = op[0]; cc[17:16] = 2'd0; cc[21:20] = 2'd0; cc[19] = 1'b0;
        ac[18] = op[0]; ac[17:16] = 2'd0; ac[21:20] = 2'd0; ac[19] = 1'b0;
        xact(cc, ac, "R4");
      end
    for (int bi = 0; bi < 3; bi++)
      for (int rep = 0; rep < 30; rep++) begin
        new_pixel(0);
        cc = $urandom; ac = $urandom;
        cc[17:16] = bi[1:0]; ac[17:16] = bi[1:0];
        xact(cc, ac, "R5");
      end
    for (int sh = 0; sh < 4; sh++)
      for (int rep = 0; rep < 30; rep++) begin
        new_pixel(0);
        cc = $urandom; ac = $urandom;
        cc[21:20] = sh[1:0]; ac[21:20] = sh[1:0];
        if (cc[17:16] == 2'd3) cc[17:16] = 2'd1;
        if (ac[17:16] == 2'd3) ac[17:16] = 2'd2;
        xact(cc, ac, "R6");
      end
    for (int cl = 0; cl < 2; cl++)
      for (int rep = 0; rep < 40; rep++) begin
        new_pixel(0);
        cc = $urandom; ac = $urandom;
        cc[19] = cl[0]; ac[19] = cl[0]; cc[21:20] = 2'd2; ac[21:20] = 2'd2;
        xact(cc, ac, "R7");
      end
    for (int code = 0; code < 8; code++)
      for (int rep = 0; rep < 24; rep++) begin
        new_pixel(rep % 2 == 0);
        cc = $urandom; ac = $urandom;
        cc[17:16] = 2'd3; cc[18] = code[0]; cc[21:20] = code[2:1];
        if (rep % 2 == 0) begin cc[15:12] = 4'd8; cc[11:8] = 4'd10; end
        xact(cc, ac, "R8");
        new_pixel(rep % 2 == 1);
        cc = $urandom; ac = $urandom;
        ac[17:16] = 2'd3; ac[18] = code[0]; ac[21:20] = code[2:1];
        if (rep % 2 == 1) begin
          ac[15:13] = 3'd4; ac[12:10] = 3'd5; cc[15:12] = 4'd8; cc[11:8] = 4'd10;
        end
        xact(cc, ac, "R9");
      end
    for (int cd = 0; cd < 4; cd++)
      for (int ad = 0; ad < 4; ad++) begin
        new_pixel(0);
        cc = $urandom; ac = $urandom;
        cc[23:22] = cd[1:0]; ac[23:22] = ad[1:0];
        xact(cc, ac, "R10");
      end
    for (int rep = 0; rep < 20; rep++) begin
      @(negedge clk);
      color_ctl = $urandom; alpha_ctl = $urandom; new_pixel(0);
      @(posedge clk); #5;
      check_regs("R11");
    end
    for (int rep = 0; rep < 2000; rep++) begin
      new_pixel(rep % 3 == 0);
      cc = $urandom; ac = $urandom;
      xact(cc, ac, (cc[17:16] == 2'd3) ? "R8" : ((ac[17:16] == 2'd3) ? "R9" : "R4"));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule